// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block buffers 9-bit words between two clock domains in first-in, first-out order. It holds up to 512 words. A word is stored on a write-clock edge only when both write qualifiers are high. A word is delivered into a registered output on a read-clock edge only when both read qualifiers are high. The two clocks may be the same net or may be unrelated. Each pointer crosses into the other domain as Gray code through a two-stage synchroniser. Every status flag is computed in the domain whose transfers it gates.

Four active-low status outputs report the fill level: none held, all held, "nearly drained" and "nearly filled". The two "nearly" thresholds come from a pair of 9-bit offsets. Both offsets take the value 7 after reset. They can be rewritten by raising the load input and making qualified writes. In that mode, each such write fills the next offset field in a fixed four-step rotation, and the word is not stored in the buffer. An output-enable input forces the data output to zero when it is low. This stands in for a released bus.

Top module: `dcfifo_prog`

## Requirements
- R1: While a reset is applied to both domains, the block is cleared. After that reset, `empty_n`=0, `full_n`=1, `almost_empty_n`=0, `almost_full_n`=1 and the registered output is 0. Both offsets are 7 and the load rotation is at its first step, whatever the block held before.
- R2: A word is stored only on a `wr_clk` edge where `wr_en_a`=1, `wr_en_b`=1, `load`=0 and the buffer is not full. A single qualifier alone stores nothing.
- R3: A read happens only on an `rd_clk` edge where `rd_en_a`=1, `rd_en_b`=1 and the buffer is not empty. Words come out in the order they were stored, and the output register updates on the read edge. With a single qualifier high, no read happens and the output holds its value.
- R4: `full_n` goes to 0 in the write-clock cycle after the 512th word is held. A write attempted while full is ignored: it neither changes the stored words nor adds a word.
- R5: `empty_n` is 0 whenever no word is held. A read attempted while empty is ignored: the output keeps its value and no pointer moves.
- R6: `almost_empty_n` is 0 exactly when the fill level, as seen in the read domain, is at or below the drain offset.
- R7: `almost_full_n` is 0 exactly when the fill level, as seen in the write domain, is at or above 512 minus the fill offset.
- R8: While `load`=1, each write-qualified edge writes one offset field and stores nothing in the buffer. The fields are written in this order, then the order wraps to the first: drain offset bits 7:0 from `din[7:0]`, drain offset bit 8 from `din[0]`, fill offset bits 7:0 from `din[7:0]`, fill offset bit 8 from `din[0]`.
- R9: With `out_en`=0 the `dout` output is all zeros. With `out_en`=1 it shows the registered read word.
- R10: A write on `wr_clk` edge k makes `empty_n` rise after the second following `rd_clk` edge, k+2, when the clocks are tied. The Gray-coded write pointer changes at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en_a | input | 1 | First write qualifier |
| wr_en_b | input | 1 | Second write qualifier |
| load | input | 1 | Routes qualified writes to the offset fields |
| din | input | 9 | Write data, or offset field data while loading |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en_a | input | 1 | First read qualifier |
| rd_en_b | input | 1 | Second read qualifier |
| out_en | input | 1 | Output enable; low forces dout to zero |
| dout | output | 9 | Gated registered read data |
| full_n | output | 1 | Low when 512 words are held |
| almost_full_n | output | 1 | Low when the level is at or above 512 minus the fill offset |
| empty_n | output | 1 | Low when no word is held |
| almost_empty_n | output | 1 | Low when the level is at or below the drain offset |

## Verification
The bench targets the exact threshold crossings: 7 and 8 words, 504 and 505 words, 511 and 512 words. A design with an off-by-one compare would move a flag one word early or late. It writes one extra word into a full buffer and then drains all 512 words. A design that stored that word would corrupt the wrap-around data or overrun its oldest entry. It reprograms both offsets, including the high bits, and runs the load rotation past its fourth step. A sequencer that did not wrap, or load writes that leaked into the buffer, would shift the thresholds or put stray words at the head of the queue. Single-qualifier transfers, reads from an empty buffer and the two-edge flag latency are each checked at the ports. Any of these would show up as a missing or extra transfer, or as a flag that moves too soon.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;

    localparam int BYTE_W      = 8;
    localparam int OFS_DEFAULT = 7;

    typedef enum logic [1:0] {
        STEP_E_LO = 2'd0,
        STEP_E_HI = 2'd1,
        STEP_F_LO = 2'd2,
        STEP_F_HI = 2'd3
    } ofs_step_e;

    typedef struct packed {
        logic push;
        logic load_wr;
    } wr_cmd_t;

    function automatic ofs_step_e next_step(input ofs_step_e s);
        case (s)
            STEP_E_LO: return STEP_E_HI;
            STEP_E_HI: return STEP_F_LO;
            STEP_F_LO: return STEP_F_HI;
            default:   return STEP_E_LO;
        endcase
    endfunction

endpackage

// File: rtl/fifo_gray_sync.sv
`timescale 1ns/1ps
module fifo_gray_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= gray_in;
            s2 <= s1;
        end
    end

    always_comb begin
        bin_out[W-1] = s2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ s2[i];
        end
    end
endmodule

// File: rtl/fifo_offset_loader.sv
`timescale 1ns/1ps
module fifo_offset_loader
    import fifo_pkg::*;
#(
    parameter int OFS_W = 9,
    parameter int LO_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_wr,
    input  logic [LO_W-1:0]  d,
    output logic [OFS_W-1:0] e_ofs,
    output logic [OFS_W-1:0] f_ofs
);
    localparam int HI_W = OFS_W - LO_W;

    ofs_step_e step;

    always_ff @(posedge clk) begin
        if (rst) begin
            step  <= STEP_E_LO;
            e_ofs <= OFS_W'(OFS_DEFAULT);
            f_ofs <= OFS_W'(OFS_DEFAULT);
        end else if (ld_wr) begin
            step <= next_step(step);
            case (step)
                STEP_E_LO: e_ofs[LO_W-1:0]     <= d;
                STEP_E_HI: e_ofs[OFS_W-1:LO_W] <= d[HI_W-1:0];
                STEP_F_LO: f_ofs[LO_W-1:0]     <= d;
                default:   f_ofs[OFS_W-1:LO_W] <= d[HI_W-1:0];
            endcase
        end
    end

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ld_wr && step == STEP_F_HI) |=> (step == STEP_E_LO)); // R8
    AST_OFS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_wr |=> ($stable(step) && $stable(e_ofs) && $stable(f_ofs))); // R8
endmodule

// File: rtl/fifo_wr_side.sv
`timescale 1ns/1ps
module fifo_wr_side
    import fifo_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_a,
    input  logic          en_b,
    input  logic          load,
    input  logic [AW-1:0] f_ofs,
    input  logic [AW:0]   rbin,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          push,
    output logic          load_wr,
    output logic          full_n,
    output logic          afull_n
);
    localparam int          PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    logic [PW-1:0] wptr, nxt, level;
    logic          full;
    wr_cmd_t       cmd;

    assign level = wptr - rbin;
    assign full  = (level == DEPTH_P);
    assign nxt   = wptr + PW'(1);

    always_comb begin
        cmd.load_wr = en_a & en_b & load;
        cmd.push    = en_a & en_b & ~load & ~full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (cmd.push) begin
            wptr  <= nxt;
            wgray <= nxt ^ (nxt >> 1);
        end
    end

    assign waddr   = wptr[AW-1:0];
    assign push    = cmd.push;
    assign load_wr = cmd.load_wr;
    assign full_n  = ~full;
    assign afull_n = ~(level >= (DEPTH_P - {1'b0, f_ofs}));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level <= DEPTH_P); // R4
    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (en_a && en_b && !full_n) |=> $stable(wptr)); // R4
    AST_LOAD_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (en_a && en_b && load) |=> $stable(wptr)); // R8
    AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1); // R10
    AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> !afull_n); // R7
endmodule

// File: rtl/fifo_rd_side.sv
`timescale 1ns/1ps
module fifo_rd_side
    import fifo_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_a,
    input  logic          en_b,
    input  logic [AW-1:0] e_ofs,
    input  logic [AW:0]   wbin,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic          pop,
    output logic          empty_n,
    output logic          aempty_n
);
    localparam int            PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    logic [PW-1:0] rptr, nxt, level;
    logic [AW-1:0] ofs_s1, ofs_s2;
    logic          empty;

    assign level = wbin - rptr;
    assign empty = (level == '0);
    assign nxt   = rptr + PW'(1);
    assign pop   = en_a & en_b & ~empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr   <= '0;
            rgray  <= '0;
            ofs_s1 <= AW'(OFS_DEFAULT);
            ofs_s2 <= AW'(OFS_DEFAULT);
        end else begin
            ofs_s1 <= e_ofs;
            ofs_s2 <= ofs_s1;
            if (pop) begin
                rptr  <= nxt;
                rgray <= nxt ^ (nxt >> 1);
            end
        end
    end

    assign raddr    = rptr[AW-1:0];
    assign empty_n  = ~empty;
    assign aempty_n = ~(level <= {1'b0, ofs_s2});

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (en_a && en_b && !empty_n) |=> $stable(rptr)); // R5
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= DEPTH_P); // R5
    AST_EMPTY_IMPLIES_AE: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> !aempty_n); // R6
endmodule

// File: rtl/dcfifo_prog.sv
`timescale 1ns/1ps
module dcfifo_prog
    import fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 9,
    parameter int LO_W   = BYTE_W
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en_a,
    input  logic              wr_en_b,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  logic              out_en,
    output logic [DATA_W-1:0] dout,
    output logic              full_n,
    output logic              almost_full_n,
    output logic              empty_n,
    output logic              almost_empty_n
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] dout_q;
    logic [PW-1:0]     wgray, rgray, wbin_r, rbin_w;
    logic [ADDR_W-1:0] waddr, raddr, e_ofs, f_ofs;
    logic              push, pop, load_wr;

    fifo_wr_side #(.AW(ADDR_W)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .en_a(wr_en_a), .en_b(wr_en_b),
        .load(load), .f_ofs(f_ofs), .rbin(rbin_w), .wgray(wgray),
        .waddr(waddr), .push(push), .load_wr(load_wr),
        .full_n(full_n), .afull_n(almost_full_n)
    );

    fifo_offset_loader #(.OFS_W(ADDR_W), .LO_W(LO_W)) u_ofs (
        .clk(wr_clk), .rst(wr_rst), .ld_wr(load_wr), .d(din[LO_W-1:0]),
        .e_ofs(e_ofs), .f_ofs(f_ofs)
    );

    fifo_gray_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .gray_in(rgray), .bin_out(rbin_w)
    );

    fifo_gray_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .gray_in(wgray), .bin_out(wbin_r)
    );

    fifo_rd_side #(.AW(ADDR_W)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .en_a(rd_en_a), .en_b(rd_en_b),
        .e_ofs(e_ofs), .wbin(wbin_r), .rgray(rgray), .raddr(raddr),
        .pop(pop), .empty_n(empty_n), .aempty_n(almost_empty_n)
    );

    always_ff @(posedge wr_clk) begin
        if (push) mem[waddr] <= din;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst)   dout_q <= '0;
        else if (pop) dout_q <= mem[raddr];
    end

    assign dout = out_en ? dout_q : '0;

    AST_IDLE_READ_HOLDS: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (!(rd_en_a && rd_en_b)) |=> $stable(dout_q)); // R3
endmodule

// File: tb/tb_dcfifo_prog.sv
`timescale 1ns/1ps
module tb_dcfifo_prog;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en_a, wr_en_b, load, rd_en_a, rd_en_b, out_en;
    logic [8:0] din;
    logic [8:0] dout;
    logic       full_n, almost_full_n, empty_n, almost_empty_n;

    int vectors = 0;
    int fails   = 0;
    int seq     = 0;
    logic [8:0] q[$];
    logic [8:0] last;

    always #2 clk = ~clk;

    dcfifo_prog dut (
        .wr_clk(clk), .wr_rst(rst), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
        .load(load), .din(din), .rd_clk(clk), .rd_rst(rst),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en), .dout(dout),
        .full_n(full_n), .almost_full_n(almost_full_n),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n)
    );

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 149 + 23) % 512);
    endfunction

    task automatic wr(input logic [8:0] d, input bit accepted);
        wr_en_a = 1'b1; wr_en_b = 1'b1; din = d;
        @(negedge clk);
        wr_en_a = 1'b0; wr_en_b = 1'b0;
        if (accepted) q.push_back(d);
    endtask

    task automatic wr_n(input int n);
        for (int i = 0; i < n; i++) begin
            wr(pat(seq), 1'b1);
            seq++;
        end
    endtask

    task automatic ld(input logic [8:0] d);
        load = 1'b1;
        wr(d, 1'b0);
        load = 1'b0;
    endtask

    task automatic rd_chk(input string tag);
        logic [8:0] exp;
        rd_en_a = 1'b1; rd_en_b = 1'b1;
        @(negedge clk);
        rd_en_a = 1'b0; rd_en_b = 1'b0;
        exp = q.pop_front();
        chk(tag, dout, exp);
        last = exp;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        q.delete();
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wr_en_a = 0; wr_en_b = 0; load = 0; rd_en_a = 0; rd_en_b = 0;
        out_en = 1; din = '0; rst = 1'b1;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 empty_n", 9'(empty_n), 9'd0);
        chk("R1 full_n", 9'(full_n), 9'd1);
        chk("R1 almost_empty_n", 9'(almost_empty_n), 9'd0);
        chk("R1 almost_full_n", 9'(almost_full_n), 9'd1);
        chk("R1 dout", dout, 9'd0);

        // R10 latency: write at edge k, empty_n high after k+2
        wr_n(1);
        chk("R10 empty_n after k", 9'(empty_n), 9'd0);
        @(negedge clk);
        chk("R10 empty_n after k+1", 9'(empty_n), 9'd0);
        @(negedge clk);
        chk("R10 empty_n after k+2", 9'(empty_n), 9'd1);

        // R6 default drain offset 7
        wr_n(6); settle();
        chk("R6 level 7", 9'(almost_empty_n), 9'd0);
        wr_n(1); settle();
        chk("R6 level 8", 9'(almost_empty_n), 9'd1);

        // R7 default fill offset 7 -> threshold 505
        wr_n(504 - 8); settle();
        chk("R7 level 504", 9'(almost_full_n), 9'd1);
        wr_n(1);
        chk("R7 level 505", 9'(almost_full_n), 9'd0);

        // R4 full flag and ignored write
        wr_n(6);
        chk("R4 level 511", 9'(full_n), 9'd1);
        wr_n(1);
        chk("R4 level 512", 9'(full_n), 9'd0);
        wr(9'h1AA, 1'b0);
        chk("R4 still full", 9'(full_n), 9'd0);
        settle();

        // R3 drain in order, R4 extra word absent
        for (int i = 0; i < 512; i++) rd_chk("R3 R4 drain order");
        settle();
        chk("R5 empty after drain", 9'(empty_n), 9'd0);

        // R5 read while empty ignored
        rd_en_a = 1; rd_en_b = 1;
        @(negedge clk);
        rd_en_a = 0; rd_en_b = 0;
        chk("R5 empty read holds dout", dout, last);

        // R2 single qualifiers store nothing
        wr_en_a = 1; din = 9'h0FF; @(negedge clk); wr_en_a = 0;
        wr_en_b = 1; din = 9'h0EE; @(negedge clk); wr_en_b = 0;
        settle();
        chk("R2 single enable no store", 9'(empty_n), 9'd0);

        // R3 single read qualifier, then real read (R5 pointer unmoved)
        wr(9'h155, 1'b1); settle();
        rd_en_a = 1; @(negedge clk); rd_en_a = 0;
        chk("R3 single rd enable holds", dout, last);
        rd_en_b = 1; @(negedge clk); rd_en_b = 0;
        chk("R3 single rd enable b holds", dout, last);
        rd_chk("R3 R5 word after empty read");

        // R9 output enable
        out_en = 0; #1;
        chk("R9 disabled output", dout, 9'd0);
        out_en = 1; #1;
        chk("R9 enabled output", dout, 9'h155);

        // R8 load drain=10, fill=0x103
        do_reset();
        ld(9'h00A); ld(9'h000); ld(9'h003); ld(9'h001);
        settle();
        chk("R8 load not stored", 9'(empty_n), 9'd0);
        wr_n(10); settle();
        chk("R8 R6 level 10 new ofs", 9'(almost_empty_n), 9'd0);
        wr_n(1); settle();
        chk("R8 R6 level 11 new ofs", 9'(almost_empty_n), 9'd1);
        wr_n(252 - 11); settle();
        chk("R8 R7 level 252", 9'(almost_full_n), 9'd1);
        wr_n(1);
        chk("R8 R7 level 253", 9'(almost_full_n), 9'd0);
        for (int i = 0; i < 253; i++) rd_chk("R8 data order after load");

        // R1 reset with data present, then R8 rotation wrap
        wr_n(3); settle();
        do_reset();
        chk("R1 reset empties", 9'(empty_n), 9'd0);
        chk("R1 reset almost_full_n", 9'(almost_full_n), 9'd1);
        ld(9'h005); ld(9'h000); ld(9'h007); ld(9'h000); ld(9'h002);
        wr_n(2); settle();
        chk("R8 wrap level 2", 9'(almost_empty_n), 9'd0);
        wr_n(1); settle();
        chk("R8 wrap level 3", 9'(almost_empty_n), 9'd1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule